// File: doc/BRIEF.md
# Segmented DAC Switch-Control Encoder

This block forms the digital front end of a segmented current-steering converter. A binary input code is cut into an upper field and a lower field. The upper field is expanded into a thermometer pattern that drives a bank of identical unit current cells. The lower field is passed on unchanged to a small set of binary-weighted cells. Every enable leaves the block from a single register bank, so all switch controls change on the same clock edge.

An input qualifier decides whether a new code is loaded on a given edge. When it is low, the previous enables are held. The block also produces a reconstruction of the steered value as an integer. This value is the number of enabled unit cells times the unit weight, plus the binary value of the lower enables. Downstream checking logic can compare it against the code that was loaded.

Top module: `segdac_enc`

## Requirements
- R1: A synchronous active-high reset clears every unit enable and every binary enable to 0 on the clock edge, so the reconstructed value reads 0.
- R2: With upper field k = in_code[CODE_W-1:LOWER_W], unit_en[i] is 1 exactly for i < k and 0 for all higher indices (k = 0 gives all zeros, k = 2^UPPER_W-1 gives all ones).
- R3: bin_en equals the lower field in_code[LOWER_W-1:0]; bit j drives the cell of weight 2^j.
- R4: A code presented with in_valid high appears on the enables after exactly one rising clock edge and not before it.
- R5: While in_valid is low, the enables and the reconstructed value keep their previous values whatever in_code carries.
- R6: When the upper field rises by one, exactly one more unit enable is set and no previously set unit enable is cleared.
- R7: model_value equals (count of set unit_en bits) × 2^LOWER_W + bin_en, and it equals the last loaded code.
- R8: On the worst-case step, where the lower field goes from all ones to all zeros and the upper field rises by one (0x0F to 0x10 by default), all binary enables clear and the next unit enable sets on the same edge.
- R9: The block has 2^UPPER_W-1+LOWER_W switch-control outputs (19 with the default 4/4 split).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all enables update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Loads in_code on the next rising edge when high |
| in_code | input | CODE_W (8) | Binary input code |
| unit_en | output | 2^UPPER_W-1 (15) | Thermometer enables for the unit cells |
| bin_en | output | LOWER_W (4) | Enables for the binary-weighted cells |
| model_value | output | CODE_W (8) | Integer reconstruction of the steered value |

## Verification
The hardest case to reach from the ports is the segment boundary. There, every binary enable drops at the same moment that a new unit cell switches in. The check must show that this happens on one edge and never in two steps. The stimulus walks every code upward, one step at a time, so that each boundary crossing follows from its predecessor. It then repeats 0x0F to 0x10 in isolation. The hold behaviour is shown by presenting a very different code with the qualifier low and reading the enables back.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    localparam int DEF_UPPER_W = 4;
    localparam int DEF_LOWER_W = 4;

    // number of identical unit cells for an upper field of the given width
    function automatic int unit_cells(input int upper_w);
        return (1 << upper_w) - 1;
    endfunction

    // total switch-control lines leaving the block
    function automatic int ctrl_lines(input int upper_w, input int lower_w);
        return unit_cells(upper_w) + lower_w;
    endfunction

endpackage

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
    parameter int UPPER_W = segdac_pkg::DEF_UPPER_W,
    localparam int UNIT_N = segdac_pkg::unit_cells(UPPER_W)
) (
    input  logic [UPPER_W-1:0] upper,
    output logic [UNIT_N-1:0]  therm
);
    // cell i switches in once the upper field exceeds its index
    for (genvar i = 0; i < UNIT_N; i++) begin : g_cell
        localparam logic [UPPER_W-1:0] IDX = UPPER_W'(i);
        assign therm[i] = (upper > IDX);
    end
endmodule

// File: rtl/segdac_out_reg.sv
module segdac_out_reg #(
    parameter int UNIT_N  = 15,
    parameter int LOWER_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [UNIT_N-1:0]  unit_d,
    input  logic [LOWER_W-1:0] bin_d,
    output logic [UNIT_N-1:0]  unit_q,
    output logic [LOWER_W-1:0] bin_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            unit_q <= '0;
            bin_q  <= '0;
        end else if (load) begin
            unit_q <= unit_d;
            bin_q  <= bin_d;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (unit_q == '0 && bin_q == '0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(unit_q) && $stable(bin_q))); // R5
endmodule

// File: rtl/segdac_recon.sv
module segdac_recon #(
    parameter int UPPER_W = segdac_pkg::DEF_UPPER_W,
    parameter int LOWER_W = segdac_pkg::DEF_LOWER_W,
    localparam int UNIT_N = segdac_pkg::unit_cells(UPPER_W),
    localparam int CODE_W = UPPER_W + LOWER_W
) (
    input  logic [UNIT_N-1:0]  unit_q,
    input  logic [LOWER_W-1:0] bin_q,
    output logic [CODE_W-1:0]  value
);
    logic [UPPER_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < UNIT_N; i++) begin
            cnt = cnt + UPPER_W'(unit_q[i]);
        end
    end

    // each unit cell weighs 2^LOWER_W, so the count lands in the upper field
    assign value = {cnt, bin_q};
endmodule

// File: rtl/segdac_enc.sv
module segdac_enc #(
    parameter int UPPER_W = segdac_pkg::DEF_UPPER_W,
    parameter int LOWER_W = segdac_pkg::DEF_LOWER_W,
    localparam int UNIT_N = segdac_pkg::unit_cells(UPPER_W),
    localparam int CODE_W = UPPER_W + LOWER_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    output logic [UNIT_N-1:0] unit_en,
    output logic [LOWER_W-1:0] bin_en,
    output logic [CODE_W-1:0] model_value
);
    logic [UPPER_W-1:0] upper_fld;
    logic [LOWER_W-1:0] lower_fld;
    logic [UNIT_N-1:0]  therm_d;

    assign upper_fld = in_code[CODE_W-1:LOWER_W];
    assign lower_fld = in_code[LOWER_W-1:0];

    segdac_therm_dec #(.UPPER_W(UPPER_W)) u_dec (
        .upper (upper_fld),
        .therm (therm_d)
    );

    segdac_out_reg #(.UNIT_N(UNIT_N), .LOWER_W(LOWER_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .load   (in_valid),
        .unit_d (therm_d),
        .bin_d  (lower_fld),
        .unit_q (unit_en),
        .bin_q  (bin_en)
    );

    segdac_recon #(.UPPER_W(UPPER_W), .LOWER_W(LOWER_W)) u_recon (
        .unit_q (unit_en),
        .bin_q  (bin_en),
        .value  (model_value)
    );

    // a thermometer word plus one has no bit in common with itself
    logic [UNIT_N:0] shape_probe;
    assign shape_probe = (UNIT_N+1)'(unit_en) + (UNIT_N+1)'(1);

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ((shape_probe & (UNIT_N+1)'(unit_en)) == '0)); // R2

    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (model_value == $past(in_code))); // R7

    AST_MONOTONE_ADD: assert property (@(posedge clk) disable iff (rst)
        ($countones(unit_en) > $countones($past(unit_en)))
        |-> ((unit_en & $past(unit_en)) == $past(unit_en))); // R6

    AST_WIDTH_SUM: assert property (@(posedge clk)
        ($bits(unit_en) + $bits(bin_en)) == segdac_pkg::ctrl_lines(UPPER_W, LOWER_W)); // R9
endmodule

// File: tb/segdac_enc_tb.sv
`timescale 1ns/1ps
module segdac_enc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_code = '0;
    logic [14:0] unit_en;
    logic [3:0]  bin_en;
    logic [7:0]  model_value;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    segdac_enc u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .unit_en(unit_en), .bin_en(bin_en), .model_value(model_value)
    );

    // {code, expected unit enables, expected binary enables}
    localparam logic [26:0] VEC [8] = '{
        {8'h00, 15'h0000, 4'h0},
        {8'h0F, 15'h0000, 4'hF},
        {8'h10, 15'h0001, 4'h0},
        {8'h1F, 15'h0001, 4'hF},
        {8'h7C, 15'h007F, 4'hC},
        {8'h80, 15'h00FF, 4'h0},
        {8'hF0, 15'h7FFF, 4'h0},
        {8'hFF, 15'h7FFF, 4'hF}
    };

    function automatic logic [14:0] therm_of(input int k);
        logic [14:0] t = '0;
        for (int i = 0; i < 15; i++) if (i < k) t[i] = 1'b1;
        return t;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_code(input logic [7:0] c);
        @(negedge clk);
        in_code  = c;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [14:0] prev_u;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 unit_en after reset", 32'(unit_en), 0);
        chk("R1 bin_en after reset", 32'(bin_en), 0);
        chk("R1 model after reset", 32'(model_value), 0);
        // R9 output count
        chk("R9 control lines", 32'($bits(unit_en) + $bits(bin_en)), 19);

        // table walk: R2 R3 R7
        for (int v = 0; v < 8; v++) begin
            load_code(VEC[v][26:19]);
            chk("R2 table unit_en", 32'(unit_en), 32'(VEC[v][18:4]));
            chk("R3 table bin_en", 32'(bin_en), 32'(VEC[v][3:0]));
            chk("R7 table model", 32'(model_value), 32'(VEC[v][26:19]));
        end

        // full upward sweep: R2 R3 R6 R7
        load_code(8'h00);
        prev_u = unit_en;
        for (int c = 1; c < 256; c++) begin
            load_code(8'(c));
            chk("R2 sweep unit_en", 32'(unit_en), 32'(therm_of(c >> 4)));
            chk("R3 sweep bin_en", 32'(bin_en), 32'(c & 15));
            chk("R7 sweep model", 32'(model_value), 32'(c));
            if ((c & 15) == 0) begin
                chk("R6 one more cell", 32'($countones(unit_en)), 32'($countones(prev_u) + 1));
                chk("R6 none removed", 32'(unit_en & prev_u), 32'(prev_u));
            end
            prev_u = unit_en;
        end

        // R8 worst-case step in isolation
        load_code(8'h0F);
        load_code(8'h10);
        chk("R8 bin_en cleared", 32'(bin_en), 0);
        chk("R8 unit_en first cell", 32'(unit_en), 32'h1);

        // R4 latency: nothing changes before the edge
        load_code(8'h33);
        @(negedge clk);
        in_code = 8'hC5;
        in_valid = 1'b1;
        #1;
        chk("R4 before edge", 32'(model_value), 32'h33);
        @(negedge clk);
        chk("R4 after edge", 32'(model_value), 32'hC5);

        // R5 hold while qualifier low
        load_code(8'h5A);
        @(negedge clk);
        in_valid = 1'b0;
        in_code = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        chk("R5 hold unit_en", 32'(unit_en), 32'(therm_of(5)));
        chk("R5 hold bin_en", 32'(bin_en), 32'hA);
        chk("R5 hold model", 32'(model_value), 32'h5A);

        // R1 reset mid-run wins over a valid load
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run unit_en", 32'(unit_en), 0);
        chk("R1 mid-run bin_en", 32'(bin_en), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule